// File: doc/BRIEF.md
# Seconds Clock with Armed Alarm and Bit Set/Clear Aliases

This block is a memory-mapped real-time clock core. It keeps a binary count of seconds that advances on each pulse of a one-second tick input, holds an alarm value to compare against, and raises an interrupt when the count reaches that value. Software reaches every register through a simple 32-bit write-strobe bus with a combinational read path.

Two single-bit registers, control and configuration, each have extra alias addresses. A write to the set alias ORs the written ones into the register. A write to the clear alias removes them. A driver can therefore change one bit without reading the register first. An alarm raises the interrupt pin only when both of two bits are set: the arm bit in the configuration register and the interrupt-enable bit in the control register. A status word tells software that the clock exists.

The oscillator, battery domain and calendar conversion sit outside this block. The tick input arrives already synchronous to `clk` as a one-cycle pulse.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset, the control, configuration, seconds and alarm registers all read 0 and `irq_alarm` is low.
- R2: Control register at 0x00 has four bits: bit 0 alarm interrupt enable, bit 1 millisecond interrupt enable, bit 2 alarm flag, bit 4 watchdog enable. A write to 0x00 replaces these four bits, a write to 0x04 ORs the written bits in, and a write to 0x08 clears the written bits. All other control bits read 0.
- R3: Configuration register at 0x60 has three bits: bit 1 wake enable, bit 2 alarm arm, bit 7 wake record. Bits 1 and 2 are replaced by a write to 0x60 and ORed in by a write to 0x64. A write to 0x68 clears any of bits 1, 2 and 7. Writes to 0x60 and 0x64 leave bit 7 unchanged.
- R4: A read of 0x04 or 0x08 returns the control register. A read of 0x64 or 0x68 returns the configuration register.
- R5: The status register at 0x10 always reads 0x8000_0000, and writes to it have no effect.
- R6: The seconds register at 0x30 increments by one on each tick, wrapping from 0xFFFF_FFFF to 0. A write loads the written value. When a write and a tick fall in the same cycle, the write wins and that tick is dropped.
- R7: The alarm register at 0x40 holds the last 32-bit value written to it.
- R8: On a tick whose incremented seconds value equals the alarm value while configuration bit 2 is set, control bit 2 becomes 1. When bit 2 is clear, no alarm is raised.
- R9: Control bit 2 stays set until software clears it. If an alarm event and a clearing write fall in the same cycle, the bit ends up set.
- R10: When an alarm event occurs while configuration bit 1 is set, configuration bit 7 becomes 1.
- R11: `irq_alarm` is high exactly when control bits 0 and 2 are both 1.
- R12: Any other offset reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_alarm | output | 1 | Alarm interrupt request |

## Verification
The set/clear logic of both bit registers is swept with 64 pairs of spread 32-bit patterns. This separates a correct masked OR or AND-NOT from a wrong mask, and shows any write path that disturbs the hardware-owned wake record. The alarm is run with the gap between the loaded count and the alarm value ranging over 1 to 6 ticks. Across that sweep, the interrupt enable and the wake enable take alternating values, so an off-by-one compare (pre- versus post-increment), a non-sticky flag or a wrong enable gating each show up in a different cycle. Further directed patterns cover the unarmed alarm, the alarm at the 32-bit wrap, a load colliding with a tick, a flag clear colliding with an alarm, and writes to undefined offsets.

// File: rtl/rtc_alarm_pkg.sv
// Package: register offsets and bit positions shared by the clock core.
// Assumes a data width of at least 32 bits, since the status word uses bit 31.
package rtc_alarm_pkg;
    localparam int unsigned OFF_CTRL     = 'h00;
    localparam int unsigned OFF_CTRL_SET = 'h04;
    localparam int unsigned OFF_CTRL_CLR = 'h08;
    localparam int unsigned OFF_STATUS   = 'h10;
    localparam int unsigned OFF_SECONDS  = 'h30;
    localparam int unsigned OFF_ALARM    = 'h40;
    localparam int unsigned OFF_CFG      = 'h60;
    localparam int unsigned OFF_CFG_SET  = 'h64;
    localparam int unsigned OFF_CFG_CLR  = 'h68;

    localparam int unsigned CB_ALM_IE  = 0;
    localparam int unsigned CB_MS_IE   = 1;
    localparam int unsigned CB_ALM_FLG = 2;
    localparam int unsigned CB_WDOG_EN = 4;

    localparam int unsigned GB_WAKE_EN = 1;
    localparam int unsigned GB_ARM     = 2;
    localparam int unsigned GB_WAKE_RC = 7;

    localparam int unsigned SB_PRESENT = 31;

    // Kinds of access the address decoder can select
    typedef enum logic [1:0] {
        WR_BASE = 2'd0,
        WR_SET  = 2'd1,
        WR_CLR  = 2'd2,
        WR_NONE = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/rtc_sec_counter.sv
// Module: seconds counter.
// Counts up on each tick and wraps at the width limit. A software load wins
// over a tick in the same cycle. The module also presents the incremented
// value and a qualified tick, so the alarm compare can act in the same cycle.
module rtc_sec_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] sec_q,
    output logic [W-1:0] sec_next,
    output logic         tick_eff
);
    // Incremented value and tick qualified by the absence of a load
    always_comb begin
        sec_next = sec_q + W'(1);
        tick_eff = tick && !load;
    end

    // Counter register: reset, load or advance
    always_ff @(posedge clk) begin
        if (!rst_n)        sec_q <= '0;
        else if (load)     sec_q <= load_val;
        else if (tick)     sec_q <= sec_next;
    end

    assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sec_q == $past(load_val)));

    assert_tick_adds_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (sec_q == W'($past(sec_q) + W'(1))));

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(sec_q));
endmodule

// File: rtl/rtc_alarm_match.sv
// Module: alarm register and compare.
// Holds the alarm value and signals an alarm event on a qualified tick whose
// incremented count equals it while armed. The arm input is the value the
// bit had before any write in the same cycle.
module rtc_alarm_match #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         tick_eff,
    input  logic [W-1:0] sec_next,
    input  logic         armed,
    output logic [W-1:0] alarm_q,
    output logic         hit
);
    // Alarm value register, written only by software
    always_ff @(posedge clk) begin
        if (!rst_n)     alarm_q <= '0;
        else if (wr_en) alarm_q <= wr_val;
    end

    // Event: armed tick landing exactly on the alarm value
    always_comb begin
        hit = tick_eff && armed && (sec_next == alarm_q);
    end

    assert_alarm_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (alarm_q == $past(wr_val)));
endmodule

// File: rtl/rtc_bit_regs.sv
// Module: control and configuration bit registers.
// Each register takes base, set-alias and clear-alias writes, and at most one
// write kind per register arrives in a cycle. An alarm event sets the alarm
// flag, and sets the wake record when wake is enabled. These hardware sets
// win over a clearing write in the same cycle.
module rtc_bit_regs
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_kind_e     ctrl_wr,
    input  wr_kind_e     cfg_wr,
    input  logic [W-1:0] wdata,
    input  logic         hit,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] cfg_q
);
    localparam logic [W-1:0] CTRL_MASK = W'((1 << CB_ALM_IE) | (1 << CB_MS_IE) |
                                            (1 << CB_ALM_FLG) | (1 << CB_WDOG_EN));
    localparam logic [W-1:0] CFG_SW_MASK = W'((1 << GB_WAKE_EN) | (1 << GB_ARM));
    localparam logic [W-1:0] CFG_HW_MASK = W'(1 << GB_WAKE_RC);
    localparam logic [W-1:0] CFG_CLR_MASK = CFG_SW_MASK | CFG_HW_MASK;

    logic [W-1:0] ctrl_d;
    logic [W-1:0] cfg_d;

    // Next control value: software write first, then the alarm event on top
    always_comb begin
        ctrl_d = ctrl_q;
        case (ctrl_wr)
            WR_BASE: ctrl_d = wdata & CTRL_MASK;
            WR_SET:  ctrl_d = ctrl_q | (wdata & CTRL_MASK);
            WR_CLR:  ctrl_d = ctrl_q & ~(wdata & CTRL_MASK);
            default: ctrl_d = ctrl_q;
        endcase
        if (hit) ctrl_d[CB_ALM_FLG] = 1'b1;
    end

    // Next configuration value: the wake record changes only by clear or event
    always_comb begin
        cfg_d = cfg_q;
        case (cfg_wr)
            WR_BASE: cfg_d = (cfg_q & CFG_HW_MASK) | (wdata & CFG_SW_MASK);
            WR_SET:  cfg_d = cfg_q | (wdata & CFG_SW_MASK);
            WR_CLR:  cfg_d = cfg_q & ~(wdata & CFG_CLR_MASK);
            default: cfg_d = cfg_q;
        endcase
        if (hit && cfg_q[GB_WAKE_EN]) cfg_d[GB_WAKE_RC] = 1'b1;
    end

    // Register update for both bit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            cfg_q  <= cfg_d;
        end
    end

    assert_event_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ctrl_q[CB_ALM_FLG]);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_ALM_FLG] && !(ctrl_wr == WR_CLR && wdata[CB_ALM_FLG]) &&
         !(ctrl_wr == WR_BASE && !wdata[CB_ALM_FLG])) |=> ctrl_q[CB_ALM_FLG]);

    assert_wake_record_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q[GB_WAKE_RC]) |-> $past(hit && cfg_q[GB_WAKE_EN]));

    assert_wake_record_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[GB_WAKE_RC] && cfg_wr != WR_CLR) |=> cfg_q[GB_WAKE_RC]);
endmodule

// File: rtl/rtc_alarm_core.sv
// Module: top of the seconds clock with alarm.
// Decodes the byte offset of a single-cycle write strobe into per-register
// write kinds, serves reads combinationally, and drives the alarm interrupt.
// Assumes tick_1s is a synchronous one-cycle pulse and W is at least 32.
module rtc_alarm_core
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq_alarm
);
    localparam logic [W-1:0] STATUS_WORD = W'(1) << SB_PRESENT;

    wr_kind_e     ctrl_wr;
    wr_kind_e     cfg_wr;
    logic         sec_load;
    logic         alarm_wr;
    logic [W-1:0] sec_q;
    logic [W-1:0] sec_next;
    logic         tick_eff;
    logic [W-1:0] alarm_q;
    logic         hit;
    logic [W-1:0] ctrl_q;
    logic [W-1:0] cfg_q;

    // Write decode: one register and one write kind per strobe
    always_comb begin
        ctrl_wr  = WR_NONE;
        cfg_wr   = WR_NONE;
        sec_load = 1'b0;
        alarm_wr = 1'b0;
        if (bus_we) begin
            case (bus_addr)
                ADDR_W'(OFF_CTRL):     ctrl_wr  = WR_BASE;
                ADDR_W'(OFF_CTRL_SET): ctrl_wr  = WR_SET;
                ADDR_W'(OFF_CTRL_CLR): ctrl_wr  = WR_CLR;
                ADDR_W'(OFF_CFG):      cfg_wr   = WR_BASE;
                ADDR_W'(OFF_CFG_SET):  cfg_wr   = WR_SET;
                ADDR_W'(OFF_CFG_CLR):  cfg_wr   = WR_CLR;
                ADDR_W'(OFF_SECONDS):  sec_load = 1'b1;
                ADDR_W'(OFF_ALARM):    alarm_wr = 1'b1;
                default: ;
            endcase
        end
    end

    // Read mux: aliases return their base register, unknown offsets return 0
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_CTRL),
            ADDR_W'(OFF_CTRL_SET),
            ADDR_W'(OFF_CTRL_CLR): bus_rdata = ctrl_q;
            ADDR_W'(OFF_CFG),
            ADDR_W'(OFF_CFG_SET),
            ADDR_W'(OFF_CFG_CLR):  bus_rdata = cfg_q;
            ADDR_W'(OFF_STATUS):   bus_rdata = STATUS_WORD;
            ADDR_W'(OFF_SECONDS):  bus_rdata = sec_q;
            ADDR_W'(OFF_ALARM):    bus_rdata = alarm_q;
            default:               bus_rdata = '0;
        endcase
    end

    rtc_sec_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1s),
        .load     (sec_load),
        .load_val (bus_wdata),
        .sec_q    (sec_q),
        .sec_next (sec_next),
        .tick_eff (tick_eff)
    );

    rtc_alarm_match #(.W(W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (alarm_wr),
        .wr_val   (bus_wdata),
        .tick_eff (tick_eff),
        .sec_next (sec_next),
        .armed    (cfg_q[GB_ARM]),
        .alarm_q  (alarm_q),
        .hit      (hit)
    );

    rtc_bit_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .cfg_wr  (cfg_wr),
        .wdata   (bus_wdata),
        .hit     (hit),
        .ctrl_q  (ctrl_q),
        .cfg_q   (cfg_q)
    );

    // Interrupt request: latched flag gated by its enable
    always_comb begin
        irq_alarm = ctrl_q[CB_ALM_FLG] && ctrl_q[CB_ALM_IE];
    end

    assert_event_lands_on_alarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (sec_q == alarm_q));

    assert_no_event_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[GB_ARM] && !ctrl_q[CB_ALM_FLG] && !(bus_we && bus_addr != ADDR_W'(OFF_CTRL_CLR)))
        |=> !ctrl_q[CB_ALM_FLG]);

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CB_ALM_IE] && !bus_we) |=> !irq_alarm);
endmodule

// File: tb/rtc_alarm_core_bench.sv
`timescale 1ns/1ps
module rtc_alarm_core_bench;
    localparam int unsigned W = 32;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1s = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          irq_alarm;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_core #(.W(W), .ADDR_W(AW)) u_rtc_alarm_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1s   (tick_1s),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_alarm (irq_alarm)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_1s = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_1s = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    initial begin : watchdog
        #(5 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v;
        logic [W-1:0] cm;
        logic [W-1:0] gm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R5 status word
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h60, v); check("R1 cfg", v, 0);
        rd(8'h30, v); check("R1 seconds", v, 0);
        rd(8'h40, v); check("R1 alarm", v, 0);
        check("R1 irq", {31'd0, irq_alarm}, 0);
        rd(8'h10, v); check("R5 status", v, 32'h8000_0000);

        // R2 control set/clear sweep, R4 alias reads, R11 irq gating
        for (int i = 0; i < 64; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'(i) * 32'h9E37_79B1;
            b = W'(i) * 32'h7F4A_7C15 ^ 32'h0000_0015;
            wr(8'h00, a); cm = a & 32'h17;
            rd(8'h00, v); check("R2 base", v, cm);
            check("R11 irq", {31'd0, irq_alarm}, {31'd0, cm[2] & cm[0]});
            wr(8'h04, b); cm = cm | (b & 32'h17);
            rd(8'h04, v); check("R4 set alias read", v, cm);
            check("R11 irq", {31'd0, irq_alarm}, {31'd0, cm[2] & cm[0]});
            wr(8'h08, a); cm = cm & ~a;
            rd(8'h08, v); check("R4 clear alias read", v, cm);
            check("R11 irq", {31'd0, irq_alarm}, {31'd0, cm[2] & cm[0]});
        end
        wr(8'h00, 0);

        // R6 seconds load, count, wrap, load beats tick
        wr(8'h30, 32'h1234_5678);
        rd(8'h30, v); check("R6 load", v, 32'h1234_5678);
        for (int n = 1; n <= 5; n++) begin
            tick();
            rd(8'h30, v); check("R6 count", v, 32'h1234_5678 + W'(n));
        end
        wr(8'h30, 32'hFFFF_FFFF); tick();
        rd(8'h30, v); check("R6 wrap", v, 0);
        wr_tick(8'h30, 32'h0000_0100);
        rd(8'h30, v); check("R6 load wins", v, 32'h0000_0100);

        // R7 alarm register
        wr(8'h40, 32'hCAFE_0042);
        rd(8'h40, v); check("R7 alarm", v, 32'hCAFE_0042);

        // R8 R10 R11 alarm sweep over distance, enables alternating
        for (int k = 1; k <= 6; k++) begin
            logic ie;
            logic we;
            ie = k[0];
            we = ~k[0];
            wr(8'h68, 32'h86);
            wr(8'h00, {31'd0, ie});
            wr(8'h60, {29'd0, 1'b1, we, 1'b0});
            wr(8'h40, 32'd1000 + W'(k));
            wr(8'h30, 32'd1000);
            for (int t = 1; t <= 8; t++) begin
                logic f;
                tick();
                f = (t >= k);
                rd(8'h00, v); check("R8 flag", v, {29'd0, f, 1'b0, ie});
                check("R11 irq", {31'd0, irq_alarm}, {31'd0, f & ie});
                rd(8'h60, v); check("R10 wake record", v, {24'd0, f & we, 4'd0, 1'b1, we, 1'b0});
            end
        end

        // R8 unarmed: no flag
        wr(8'h00, 0); wr(8'h68, 32'h86);
        wr(8'h40, 32'd50); wr(8'h30, 32'd48);
        repeat (4) tick();
        rd(8'h00, v); check("R8 unarmed", v, 0);

        // R8 alarm at wrap to zero, with wake enabled
        wr(8'h64, 32'h06); wr(8'h40, 0); wr(8'h30, 32'hFFFF_FFFF);
        tick();
        rd(8'h00, v); check("R8 wrap alarm", v, 32'h4);
        rd(8'h60, v); check("R10 wrap wake", v, 32'h86);

        // R9 clear colliding with alarm event keeps the flag
        wr(8'h40, 32'd20); wr(8'h30, 32'd19);
        wr_tick(8'h08, 32'h4);
        rd(8'h00, v); check("R9 set beats clear", v, 32'h4);
        wr(8'h08, 32'h4);
        rd(8'h00, v); check("R9 clear", v, 0);

        // R3 configuration sweep with the wake record held at 1
        gm = 32'h86;
        for (int i = 0; i < 64; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'(i) * 32'h85EB_CA6B;
            b = W'(i) * 32'hC2B2_AE35;
            wr(8'h60, a); gm = (gm & 32'h80) | (a & 32'h06);
            rd(8'h60, v); check("R3 base", v, gm);
            wr(8'h64, b); gm = gm | (b & 32'h06);
            rd(8'h64, v); check("R4 cfg set alias read", v, gm);
        end
        wr(8'h68, 32'h80); gm = gm & ~32'h80;
        rd(8'h68, v); check("R3 clear record", v, gm);

        // R5 status write ignored, R12 undefined offsets
        wr(8'h00, 32'h11);
        wr(8'h30, 32'd7);
        wr(8'h40, 32'd9);
        wr(8'h10, 0);
        rd(8'h10, v); check("R5 status write", v, 32'h8000_0000);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h6C, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R12 ctrl kept", v, 32'h11);
        rd(8'h60, v); check("R12 cfg kept", v, gm);
        rd(8'h30, v); check("R12 seconds kept", v, 32'd7);
        rd(8'h40, v); check("R12 alarm kept", v, 32'd9);
        rd(8'h20, v); check("R12 read zero", v, 0);
        rd(8'h50, v); check("R12 read zero", v, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule